// File: doc/BRIEF.md
# Turn-Triggered Acquisition Controller

This block sequences data capture for a set of analog sample memories. Software programs a turn-count register and then sets a mode bit in a control/status register. Once the mode bit is set, the card memories belong to the acquisition engine, and the engine arms. It waits for the next revolution (turn) marker. After that marker arrives it raises a capture enable and steps a capture address every clock until the requested number of turns has passed.

Two capture styles are offered. In single-shot capture the engine records the programmed number of turns, reports completion and waits. In continuous capture the engine keeps recording and ignores turn counts. If software then drops the continuous bit while leaving the mode bit set, the engine records a tail of the programmed number of further turns and then finishes. Clearing the mode bit halts capture at once, from any state, and hands the memories back to programmed readout.

Top module: `acq_ctrl_top`

## Requirements
- R1: After reset the control word reads 0, the turn-count register reads 0, `cap_en` is 0, `cap_addr` is 0 and `engine_owns` is 0.
- R2: `reg_sel`=1 selects the 32-bit turn-count register, which reads back exactly as written. `reg_sel`=0 selects the control word, which reads mode at bit 0, active at bit 1, done at bit 2 and continuous at bit 3, with bits 31..4 always 0. Writes to bits 1 and 2 are ignored.
- R3: A write that changes mode from 0 to 1 arms the engine without capturing. Capture (active=1) begins on the clock edge of the first turn marker that arrives after the arming write.
- R4: In single-shot capture, active falls and done rises on the edge of the Nth turn marker after the start marker, where N is the turn count. With N=0, the start marker sets done directly and active never rises.
- R5: Done stays set until mode is cleared. A control write with bit 0 = 0 clears active, done, `cap_en` and `cap_addr` on that edge, from any state.
- R6: While the continuous bit is 1, turn markers never end a capture.
- R7: A control write that clears the continuous bit while mode stays 1 and capture is active starts a tail. Done is set on the Nth later turn marker.
- R8: `cap_en` equals active. `cap_addr` is 0 in the first capture cycle, rises by one per capture cycle and wraps from BUF_DEPTH-1 to 0.
- R9: `engine_owns` follows the mode bit, and `cap_en` is never 1 while `engine_owns` is 0.
- R10: A turn marker in the same cycle as a control write is ignored. The write takes effect and the marker neither starts, counts nor ends a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = turn-count register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| turn_mark | input | 1 | One-cycle turn marker pulse |
| cap_en | output | 1 | Capture enable to the card memories |
| cap_addr | output | ADDR_W | Capture address to the card memories |
| engine_owns | output | 1 | 1 = memories driven by the engine, 0 = programmed readout |

## Verification
A register write and a turn marker can land on the same clock edge. The marker is the event that starts, counts and ends a capture, and the write is what arms, halts or drops into the tail. The bench deliberately places markers in the very cycle of an arming write, a continuous-bit clear and a mode clear. In each case the control word is judged on the following cycle: still armed rather than active, the tail needing its full count of later markers, and everything halted. A behavioural model checks every cycle in between.

// File: rtl/acq_pkg.sv
package acq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2,
      ST_DONE  = 2'd3
   } acq_state_t;

   localparam int BIT_MODE   = 0;
   localparam int BIT_ACTIVE = 1;
   localparam int BIT_DONE   = 2;
   localparam int BIT_CONT   = 3;

   localparam logic SEL_CTRL  = 1'b0;
   localparam logic SEL_TURNS = 1'b1;
endpackage

// File: rtl/acq_csr.sv
module acq_csr
   import acq_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             sel,
   input  logic [REG_W-1:0] wdata,
   input  logic             st_active,
   input  logic             st_done,
   output logic             ctrl_wr,
   output logic             new_mode,
   output logic             new_cont,
   output logic             mode_q,
   output logic             cont_q,
   output logic [REG_W-1:0] turns_q,
   output logic [REG_W-1:0] rdata
);
   if (REG_W < 4) begin : g_bad_width
      $error("acq_csr: REG_W must hold the four control bits");
   end

   logic [REG_W-1:0] ctrl_word;

   assign ctrl_wr  = wr && (sel == SEL_CTRL);
   assign new_mode = wdata[BIT_MODE];
   assign new_cont = wdata[BIT_CONT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         cont_q  <= 1'b0;
         turns_q <= '0;
      end else begin
         if (ctrl_wr) begin
            mode_q <= new_mode;
            cont_q <= new_cont;
         end
         if (wr && (sel == SEL_TURNS)) turns_q <= wdata;
      end
   end

   always_comb begin
      ctrl_word             = '0;
      ctrl_word[BIT_MODE]   = mode_q;
      ctrl_word[BIT_ACTIVE] = st_active;
      ctrl_word[BIT_DONE]   = st_done;
      ctrl_word[BIT_CONT]   = cont_q;
   end

   assign rdata = (sel == SEL_TURNS) ? turns_q : ctrl_word;
endmodule

// File: rtl/acq_turn_cnt.sv
module acq_turn_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] target,
   output logic             reached
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("acq_turn_cnt: CNT_W must be positive");
   end

   logic [CNT_W-1:0] seen_q;
   logic [CNT_W:0]   seen_nxt;

   assign seen_nxt = {1'b0, seen_q} + {{CNT_W{1'b0}}, 1'b1};
   assign reached  = seen_nxt >= {1'b0, target};

   always_ff @(posedge clk) begin
      if (!rst_n)   seen_q <= '0;
      else if (clr) seen_q <= '0;
      else if (inc) seen_q <= seen_nxt[CNT_W-1:0];
   end
endmodule

// File: rtl/acq_addr_gen.sv
module acq_addr_gen #(
   parameter int DEPTH  = 48,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
   localparam bit                POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("acq_addr_gen: DEPTH must be at least 2");
   end
   if ((1 << ADDR_W) < DEPTH) begin : g_bad_addr
      $error("acq_addr_gen: ADDR_W too narrow for DEPTH");
   end

   logic [ADDR_W-1:0] step;

   if (POW2) begin : g_natural_wrap
      assign step = addr + 1'b1;
   end else begin : g_compare_wrap
      assign step = (addr == LAST) ? '0 : addr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   addr <= '0;
      else if (clr) addr <= '0;
      else if (adv) addr <= step;
   end
endmodule

// File: rtl/acq_ctrl_top.sv
module acq_ctrl_top
   import acq_pkg::*;
#(
   parameter  int REG_W     = 32,
   parameter  int BUF_DEPTH = 48,
   localparam int ADDR_W    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              turn_mark,
   output logic              cap_en,
   output logic [ADDR_W-1:0] cap_addr,
   output logic              engine_owns
);
   acq_state_t       state_q, state_d;
   logic             act_w, done_w, mode_q, cont_q;
   logic             ctrl_wr, new_mode, new_cont;
   logic [REG_W-1:0] turns_q;
   logic             cnt_clr, cnt_inc, reached, addr_clr;
   logic             mode_clear, mode_rise, cont_fall;

   assign act_w  = (state_q == ST_RUN);
   assign done_w = (state_q == ST_DONE);

   acq_csr #(.REG_W(REG_W)) u_csr (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .st_active(act_w), .st_done(done_w), .ctrl_wr(ctrl_wr),
      .new_mode(new_mode), .new_cont(new_cont), .mode_q(mode_q),
      .cont_q(cont_q), .turns_q(turns_q), .rdata(reg_rdata)
   );

   acq_turn_cnt #(.CNT_W(REG_W)) u_turns (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
      .target(turns_q), .reached(reached)
   );

   acq_addr_gen #(.DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(addr_clr), .adv(act_w), .addr(cap_addr)
   );

   assign mode_clear = ctrl_wr && !new_mode;
   assign mode_rise  = ctrl_wr && new_mode && !mode_q;
   assign cont_fall  = ctrl_wr && new_mode && mode_q && cont_q && !new_cont;

   always_comb begin
      state_d  = state_q;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      addr_clr = 1'b0;
      if (mode_clear) begin
         state_d  = ST_IDLE;
         cnt_clr  = 1'b1;
         addr_clr = 1'b1;
      end else if (mode_rise) begin
         state_d = ST_ARMED;
         cnt_clr = 1'b1;
      end else if (ctrl_wr) begin
         cnt_clr = cont_fall && act_w;
      end else if (turn_mark) begin
         unique case (state_q)
            ST_ARMED: begin
               if (!cont_q && (turns_q == '0)) begin
                  state_d = ST_DONE;
               end else begin
                  state_d  = ST_RUN;
                  addr_clr = 1'b1;
                  cnt_clr  = 1'b1;
               end
            end
            ST_RUN: begin
               if (!cont_q) begin
                  if (reached) state_d = ST_DONE;
                  else         cnt_inc = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign cap_en      = act_w;
   assign engine_owns = mode_q;
endmodule

// File: rtl/acq_ctrl_chk.sv
module acq_ctrl_chk #(
   parameter int DEPTH  = 48,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              act_w,
   input logic              done_w,
   input logic              mode_w,
   input logic              cont_w,
   input logic              turn_mark,
   input logic              ctrl_write,
   input logic              halt_write,
   input logic              cap_en,
   input logic [ADDR_W-1:0] cap_addr,
   input logic              engine_owns
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_w && done_w));

   p_start_on_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_w) |-> $past(turn_mark) && !$past(ctrl_write));

   p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_w) |-> !mode_w);

   p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      halt_write |=> !cap_en && !done_w && cap_addr == '0);

   p_cont_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      act_w && cont_w && !ctrl_write |=> act_w);

   p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en && $past(cap_en) |->
         cap_addr == (($past(cap_addr) == LAST) ? '0 : $past(cap_addr) + 1'b1));

   p_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !engine_owns |-> !cap_en);
endmodule

bind acq_ctrl_top acq_ctrl_chk #(.DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .act_w(act_w), .done_w(done_w), .mode_w(mode_q),
   .cont_w(cont_q), .turn_mark(turn_mark),
   .ctrl_write(reg_wr && !reg_sel),
   .halt_write(reg_wr && !reg_sel && !reg_wdata[0]),
   .cap_en(cap_en), .cap_addr(cap_addr), .engine_owns(engine_owns)
);

// File: tb/acq_ctrl_top_test.sv
module acq_ctrl_top_test;
   localparam int DEPTH = 48;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_sel = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          turn_mark = 1'b0;
   logic          cap_en;
   logic [AW-1:0] cap_addr;
   logic          engine_owns;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   acq_ctrl_top #(.REG_W(32), .BUF_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .turn_mark(turn_mark),
      .cap_en(cap_en), .cap_addr(cap_addr), .engine_owns(engine_owns)
   );

   // behavioural reference
   bit          m_mode, m_cont, m_active, m_done, m_armed;
   logic [32:0] m_seen;
   logic [31:0] m_req;
   int          m_addr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_cont = 0; m_active = 0; m_done = 0; m_armed = 0;
         m_seen = '0; m_req = '0; m_addr = 0;
      end else begin
         if (m_active) m_addr = (m_addr + 1) % DEPTH;
         if (reg_wr && !reg_sel) begin
            if (!reg_wdata[0]) begin
               m_armed = 0; m_active = 0; m_done = 0; m_addr = 0;
            end else if (!m_mode) begin
               m_armed = 1; m_active = 0; m_done = 0;
            end else if (m_cont && !reg_wdata[3] && m_active) begin
               m_seen = '0;
            end
            m_mode = reg_wdata[0];
            m_cont = reg_wdata[3];
         end else begin
            if (m_armed && turn_mark) begin
               m_armed = 0;
               if (!m_cont && m_req == 0) m_done = 1;
               else begin m_active = 1; m_seen = '0; m_addr = 0; end
            end else if (m_active && turn_mark && !m_cont) begin
               m_seen = m_seen + 1;
               if (m_seen >= {1'b0, m_req}) begin m_active = 0; m_done = 1; end
            end
            if (reg_wr && reg_sel) m_req = reg_wdata;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] ctrl_exp();
      return {28'b0, m_cont, m_done, m_active, m_mode};
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         check(reg_rdata == (reg_sel ? m_req : ctrl_exp()), "R2 model rdata",
               reg_rdata, reg_sel ? m_req : ctrl_exp());
         check(cap_en == m_active, "R8 model cap_en", 32'(cap_en), 32'(m_active));
         check(int'(cap_addr) == m_addr, "R8 model cap_addr", 32'(cap_addr), 32'(m_addr));
         check(engine_owns == m_mode, "R9 model owner", 32'(engine_owns), 32'(m_mode));
      end
   end

   task automatic cyc(input bit wr, input bit sel, input logic [31:0] wd, input bit mk);
      reg_wr = wr; reg_sel = sel; reg_wdata = wd; turn_mark = mk;
      @(posedge clk); #2;
      reg_wr = 0; turn_mark = 0; reg_sel = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, '0, 0);
   endtask

   task automatic expect_ctrl(input logic [31:0] exp, input string tag);
      @(negedge clk);
      check(reg_rdata == exp, tag, reg_rdata, exp);
   endtask

   task automatic run_test();
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      check(reg_rdata == 0 && !cap_en && cap_addr == 0 && !engine_owns,
            "R1 reset state", reg_rdata, 0);
      reg_sel = 1; #1;
      check(reg_rdata == 0, "R1 reset turn count", reg_rdata, 0);
      #2;
      cyc(1, 1, 32'hDEAD_BEEF, 0);
      reg_sel = 1; @(negedge clk);
      check(reg_rdata == 32'hDEAD_BEEF, "R2 turn count readback", reg_rdata, 32'hDEAD_BEEF);
      @(posedge clk); #2; reg_sel = 0;
      cyc(1, 0, 32'hFFFF_FFF6, 0);
      expect_ctrl(32'h0, "R2 status bits ignored");
      cyc(1, 1, 32'd3, 0);
      // single shot, three turns
      cyc(1, 0, 32'h1, 0);
      expect_ctrl(32'h1, "R3 armed not active");
      idle(2);
      expect_ctrl(32'h1, "R3 waits for marker");
      cyc(0, 0, '0, 1);
      expect_ctrl(32'h3, "R3 capture starts on marker");
      idle(3); cyc(0, 0, '0, 1);
      idle(2); cyc(0, 0, '0, 1);
      expect_ctrl(32'h3, "R4 still active after two turns");
      idle(2); cyc(0, 0, '0, 1);
      expect_ctrl(32'h5, "R4 done after third turn");
      idle(4); cyc(0, 0, '0, 1);
      expect_ctrl(32'h5, "R5 done holds");
      cyc(1, 0, 32'h0, 0);
      expect_ctrl(32'h0, "R5 mode clear");
      // zero turn count
      cyc(1, 1, 32'd0, 0);
      cyc(1, 0, 32'h1, 0);
      cyc(0, 0, '0, 1);
      expect_ctrl(32'h5, "R4 zero count done at start");
      check(!cap_en, "R4 zero count no capture", 32'(cap_en), 0);
      cyc(1, 0, 32'h0, 0);
      // continuous with tail
      cyc(1, 1, 32'd2, 0);
      cyc(1, 0, 32'h9, 0);
      idle(1); cyc(0, 0, '0, 1);
      expect_ctrl(32'hB, "R6 continuous active");
      for (int k = 0; k < 6; k++) begin idle(9); cyc(0, 0, '0, 1); end
      expect_ctrl(32'hB, "R6 markers do not end continuous");
      cyc(1, 0, 32'h1, 1);
      expect_ctrl(32'h3, "R7 R10 tail starts, marker ignored");
      idle(3); cyc(0, 0, '0, 1);
      expect_ctrl(32'h3, "R7 one tail turn");
      idle(3); cyc(0, 0, '0, 1);
      expect_ctrl(32'h5, "R7 tail complete");
      cyc(1, 0, 32'h0, 0);
      // collisions
      cyc(1, 0, 32'h1, 1);
      expect_ctrl(32'h1, "R10 arming write beats marker");
      idle(1); cyc(0, 0, '0, 1);
      expect_ctrl(32'h3, "R3 starts on later marker");
      idle(5);
      cyc(1, 0, 32'h0, 1);
      expect_ctrl(32'h0, "R10 R5 halt beats marker");
      check(!cap_en && cap_addr == 0 && !engine_owns, "R9 released",
            32'(cap_addr), 0);
      idle(3);
   endtask

   initial begin
      fork
         run_test();
         begin
            repeat (100000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule